// File: doc/BRIEF.md
# Parallel Candidate Quotient Selector

This block is the correction stage of a division step that first predicts a wide chunk of the quotient and then settles its last few digits. It takes a rounded prediction of the quotient chunk, the divisor and the current partial remainder. Every possible low-digit pattern of the chunk is appended to the prediction to form one candidate. Each candidate is multiplied by the divisor, and all the products are compared with the remainder at the same time. The selector keeps the largest candidate whose product still fits under the remainder, so the remainder it returns is never negative.

The chosen chunk and its new remainder (remainder minus chunk times divisor) are registered and appear one cycle after a valid input. The remainder is taken from the product that was already formed for the winning candidate, so no second multiplier is used. If even the all-zero-suffix candidate is too large, the prediction was too high. In that case the selector returns that candidate minus one unit and raises an error flag that a testbench can watch.

The output stage is a two-state machine. `ST_EMPTY` means no result is held and `ST_FULL` means a result is held. The transitions are:
- load: `ST_EMPTY` to `ST_FULL` when `in_valid` is high.
- reload: `ST_FULL` to `ST_FULL` when `in_valid` is high.
- drain: `ST_FULL` to `ST_EMPTY` when `in_valid` is low.
- idle: `ST_EMPTY` to `ST_EMPTY` when `in_valid` is low.

Top module: `qsel_unit`

## Requirements
- R1: While `rst_n` is low, and until the first accepted input, `out_valid`, `out_err`, `out_quot` and `out_rem` are all zero.
- R2: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, so back-to-back inputs give back-to-back results.
- R3: Candidate k (k from 0 to 2^SFX_W-1) is `{in_pred, k}`: the prediction in the upper PRED_W bits and k in the low SFX_W bits. When `out_err` is low, `out_quot[PRED_W+SFX_W-1:SFX_W]` equals the captured prediction.
- R4: When `out_err` is low, `out_quot * divisor` does not exceed the captured remainder (no overshoot).
- R5: When `out_err` is low, either the low SFX_W bits of `out_quot` are all ones, or `(out_quot+1) * divisor` exceeds the captured remainder.
- R6: `out_rem` equals the captured remainder minus `out_quot * divisor`, taken modulo 2^REM_W.
- R7: When `{in_pred, 0} * divisor` exceeds the remainder, `out_err` is 1 and `out_quot` is `{in_pred, 0} - 1` (modulo 2^(PRED_W+SFX_W)). Otherwise `out_err` is 0.
- R8: A zero divisor selects the all-ones suffix and returns the remainder unchanged.
- R9: In a cycle with `in_valid` low, `out_quot`, `out_rem` and `out_err` keep their values and changes on the data inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Data inputs are valid this cycle |
| in_pred | input | PRED_W (17) | Rounded quotient prediction |
| in_div | input | DIV_W (12) | Divisor |
| in_rem | input | REM_W (32) | Current partial remainder |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_quot | output | PRED_W+SFX_W (20) | Selected quotient chunk |
| out_rem | output | REM_W (32) | Remainder after subtracting chunk times divisor |
| out_err | output | 1 | No candidate fitted; prediction was too high |

## Verification
The bench goes after the boundaries of the selection:
- A remainder that lands exactly on a candidate product. A comparison written as strict less-than would pick one candidate too low here and leave a remainder equal to the divisor.
- The lowest and the highest suffix. A priority chain with the wrong direction, or an off-by-one in candidate formation, would return the wrong end of the range.
- A zero divisor. Here all products tie at zero, and only a true largest-fit rule picks the all-ones suffix.
- Over-predictions, including the largest prediction with a zero remainder. A design that mishandles the fallback would leave the flag low, return the zero-suffix candidate with a wrapped remainder, or subtract the divisor in the wrong direction.
- Idle cycles with changing inputs. These expose registers that load without the valid qualifier.

// File: rtl/qsel_pkg.sv
package qsel_pkg;

    // Occupancy of the registered output stage.
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } qsel_state_e;

endpackage

// File: rtl/qsel_cand_bank.sv
// Forms every candidate {pred, k}, multiplies each by the divisor and flags
// the ones whose product does not exceed the remainder.
module qsel_cand_bank #(
    parameter int PRED_W = 17,
    parameter int SFX_W  = 3,
    parameter int DIV_W  = 12,
    parameter int REM_W  = PRED_W + SFX_W + DIV_W
) (
    input  logic [PRED_W-1:0]                            pred,
    input  logic [DIV_W-1:0]                             div,
    input  logic [REM_W-1:0]                             rem,
    output logic [(1<<SFX_W)-1:0][PRED_W+SFX_W+DIV_W-1:0] prods,
    output logic [(1<<SFX_W)-1:0]                        fits
);
    localparam int NCAND  = 1 << SFX_W;
    localparam int CAND_W = PRED_W + SFX_W;
    localparam int PROD_W = CAND_W + DIV_W;
    localparam int CMP_W  = (PROD_W > REM_W) ? PROD_W : REM_W;

    for (genvar k = 0; k < NCAND; k++) begin : g_cand
        localparam logic [SFX_W-1:0] SFX = SFX_W'(k);
        logic [CAND_W-1:0] cand;
        logic [PROD_W-1:0] prod;

        assign cand     = {pred, SFX};
        assign prod     = PROD_W'(cand) * PROD_W'(div);
        assign prods[k] = prod;
        assign fits[k]  = CMP_W'(prod) <= CMP_W'(rem);
    end
endmodule

// File: rtl/qsel_pick.sv
// Keeps the highest fitting candidate; falls back to {pred,0}-1 when none fits.
module qsel_pick #(
    parameter int PRED_W = 17,
    parameter int SFX_W  = 3,
    parameter int DIV_W  = 12,
    parameter int REM_W  = PRED_W + SFX_W + DIV_W
) (
    input  logic [PRED_W-1:0]                            pred,
    input  logic [DIV_W-1:0]                             div,
    input  logic [REM_W-1:0]                             rem,
    input  logic [(1<<SFX_W)-1:0][PRED_W+SFX_W+DIV_W-1:0] prods,
    input  logic [(1<<SFX_W)-1:0]                        fits,
    output logic [PRED_W+SFX_W-1:0]                      quot,
    output logic [REM_W-1:0]                             rem_out,
    output logic                                         err
);
    localparam int NCAND  = 1 << SFX_W;
    localparam int CAND_W = PRED_W + SFX_W;
    localparam int PROD_W = CAND_W + DIV_W;

    logic [SFX_W-1:0]  sel_idx;
    logic              hit;
    logic [PROD_W-1:0] sel_prod;

    // Ascending scan: the last fitting index wins, i.e. the largest candidate.
    always_comb begin
        sel_idx = '0;
        hit     = 1'b0;
        for (int k = 0; k < NCAND; k++) begin
            if (fits[k]) begin
                sel_idx = SFX_W'(k);
                hit     = 1'b1;
            end
        end
    end

    always_comb begin
        if (hit) begin
            quot     = {pred, sel_idx};
            sel_prod = prods[sel_idx];
        end else begin
            // One unit below the zero-suffix candidate; its product is the
            // zero-suffix product less one divisor.
            quot     = {pred, {SFX_W{1'b0}}} - CAND_W'(1);
            sel_prod = prods[0] - PROD_W'(div);
        end
        rem_out = rem - REM_W'(sel_prod);
        err     = !hit;
    end
endmodule

// File: rtl/qsel_unit.sv
module qsel_unit
    import qsel_pkg::*;
#(
    parameter int PRED_W = 17,
    parameter int SFX_W  = 3,
    parameter int DIV_W  = 12,
    parameter int REM_W  = PRED_W + SFX_W + DIV_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [PRED_W-1:0]       in_pred,
    input  logic [DIV_W-1:0]        in_div,
    input  logic [REM_W-1:0]        in_rem,
    output logic                    out_valid,
    output logic [PRED_W+SFX_W-1:0] out_quot,
    output logic [REM_W-1:0]        out_rem,
    output logic                    out_err
);
    localparam int NCAND  = 1 << SFX_W;
    localparam int CAND_W = PRED_W + SFX_W;
    localparam int PROD_W = CAND_W + DIV_W;

    qsel_state_e state_q, state_d;

    logic [NCAND-1:0][PROD_W-1:0] prods;
    logic [NCAND-1:0]             fits;
    logic [CAND_W-1:0]            nxt_quot;
    logic [REM_W-1:0]             nxt_rem;
    logic                         nxt_err;

    qsel_cand_bank #(
        .PRED_W(PRED_W), .SFX_W(SFX_W), .DIV_W(DIV_W), .REM_W(REM_W)
    ) u_bank (
        .pred  (in_pred),
        .div   (in_div),
        .rem   (in_rem),
        .prods (prods),
        .fits  (fits)
    );

    qsel_pick #(
        .PRED_W(PRED_W), .SFX_W(SFX_W), .DIV_W(DIV_W), .REM_W(REM_W)
    ) u_pick (
        .pred    (in_pred),
        .div     (in_div),
        .rem     (in_rem),
        .prods   (prods),
        .fits    (fits),
        .quot    (nxt_quot),
        .rem_out (nxt_rem),
        .err     (nxt_err)
    );

    // Next-state logic: load, reload, drain, idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // Result registers: load only on an accepted input.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_quot <= '0;
            out_rem  <= '0;
            out_err  <= 1'b0;
        end else if (in_valid) begin
            out_quot <= nxt_quot;
            out_rem  <= nxt_rem;
            out_err  <= nxt_err;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/qsel_unit_chk.sv
module qsel_unit_chk #(
    parameter int PRED_W = 17,
    parameter int SFX_W  = 3,
    parameter int DIV_W  = 12,
    parameter int REM_W  = PRED_W + SFX_W + DIV_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [PRED_W-1:0]       in_pred,
    input logic [DIV_W-1:0]        in_div,
    input logic [REM_W-1:0]        in_rem,
    input logic                    out_valid,
    input logic [PRED_W+SFX_W-1:0] out_quot,
    input logic [REM_W-1:0]        out_rem,
    input logic                    out_err
);
    localparam int CAND_W = PRED_W + SFX_W;
    localparam int PROD_W = CAND_W + DIV_W;
    localparam int CMP_W  = (PROD_W > REM_W) ? PROD_W : REM_W;

    logic [PRED_W-1:0] cap_pred;
    logic [DIV_W-1:0]  cap_div;
    logic [REM_W-1:0]  cap_rem;
    logic [PROD_W-1:0] chk_prod;
    logic [PROD_W-1:0] zero_prod;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_pred <= '0;
            cap_div  <= '0;
            cap_rem  <= '0;
        end else if (in_valid) begin
            cap_pred <= in_pred;
            cap_div  <= in_div;
            cap_rem  <= in_rem;
        end
    end

    assign chk_prod  = PROD_W'(out_quot) * PROD_W'(cap_div);
    assign zero_prod = PROD_W'({cap_pred, {SFX_W{1'b0}}}) * PROD_W'(cap_div);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r3_prefix_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (out_quot[CAND_W-1:SFX_W] == cap_pred));
    a_r4_no_overshoot: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (CMP_W'(chk_prod) <= CMP_W'(cap_rem)));
    a_r6_rem_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_rem == cap_rem - REM_W'(chk_prod)));
    a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err) |-> (CMP_W'(zero_prod) > CMP_W'(cap_rem)));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_quot) && $stable(out_rem) && $stable(out_err)));
endmodule

bind qsel_unit qsel_unit_chk #(
    .PRED_W(PRED_W), .SFX_W(SFX_W), .DIV_W(DIV_W), .REM_W(REM_W)
) u_chk (.*);

// File: tb/qsel_unit_bench.sv
module qsel_unit_bench;
    localparam int PRED_W = 17;
    localparam int SFX_W  = 3;
    localparam int DIV_W  = 12;
    localparam int REM_W  = 32;
    localparam int CAND_W = PRED_W + SFX_W;
    localparam int NVEC   = 8;

    // Stimulus table with the expected error flag per vector.
    localparam logic [PRED_W-1:0] V_PRED [NVEC] = '{17'd100, 17'd0, 17'd5, 17'd10,
                                                    17'd1000, 17'd2000, 17'd131071, 17'd50};
    localparam logic [DIV_W-1:0]  V_DIV  [NVEC] = '{12'd7, 12'd1, 12'd0, 12'd100,
                                                    12'd4095, 12'd3000, 12'd4095, 12'd9};
    localparam logic [REM_W-1:0]  V_REM  [NVEC] = '{32'd5638, 32'd3, 32'd0, 32'd7999,
                                                    32'hFFFF_FFFF, 32'd48006000, 32'd0, 32'd3608};
    localparam logic              V_ERR  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1,
                                                    1'b0, 1'b0, 1'b1, 1'b0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [PRED_W-1:0] in_pred = '0;
    logic [DIV_W-1:0]  in_div = '0;
    logic [REM_W-1:0]  in_rem = '0;
    logic              out_valid;
    logic [CAND_W-1:0] out_quot;
    logic [REM_W-1:0]  out_rem;
    logic              out_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    qsel_unit #(.PRED_W(PRED_W), .SFX_W(SFX_W), .DIV_W(DIV_W), .REM_W(REM_W)) u_qsel_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
        .in_div(in_div), .in_rem(in_rem), .out_valid(out_valid),
        .out_quot(out_quot), .out_rem(out_rem), .out_err(out_err)
    );

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input longint unsigned p, input longint unsigned d, input longint unsigned x,
                         output longint unsigned q, output longint unsigned r, output bit e);
        bit hit = 1'b0;
        q = 0;
        for (int k = 0; k < (1 << SFX_W); k++) begin
            longint unsigned c = (p << SFX_W) | longint'(k);
            if (c * d <= x) begin
                q   = c;
                hit = 1'b1;
            end
        end
        if (!hit) q = ((p << SFX_W) - 1) & ((64'd1 << CAND_W) - 1);
        e = !hit;
        r = (x - q * d) & 64'hFFFF_FFFF;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 5000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        longint unsigned eq, er, last_q, last_r;
        bit ee;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", out_valid, 0);
        check("R1 err", out_err, 0);
        check("R1 quot", out_quot, 0);
        check("R1 rem", out_rem, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", out_valid, 0);

        // Table walk, back-to-back inputs.
        for (int i = 0; i < NVEC; i++) begin
            in_valid = 1'b1;
            in_pred  = V_PRED[i];
            in_div   = V_DIV[i];
            in_rem   = V_REM[i];
            @(negedge clk);
            model(V_PRED[i], V_DIV[i], V_REM[i], eq, er, ee);
            check("R2 valid", out_valid, 1);
            check("R7 err flag", out_err, V_ERR[i]);
            check("R7 model err", out_err, ee);
            check("R3/R5 quot", out_quot, eq);
            check("R6 rem", out_rem, er);
            if (!V_ERR[i]) begin
                check("R3 prefix", out_quot >> SFX_W, V_PRED[i]);
                check("R4 no overshoot", (longint'(out_quot) * V_DIV[i] <= V_REM[i]), 1);
                if ((out_quot & 7) != 7)
                    check("R5 maximal", ((longint'(out_quot) + 1) * V_DIV[i] > V_REM[i]), 1);
            end
            last_q = eq;
            last_r = er;
        end

        // Directed hand values.
        in_valid = 1'b1; in_pred = 17'd0; in_div = 12'd0; in_rem = 32'd12345;
        @(negedge clk);
        check("R8 zero divisor quot", out_quot, 7);
        check("R8 zero divisor rem", out_rem, 12345);
        in_pred = 17'd10; in_div = 12'd100; in_rem = 32'd7999;
        @(negedge clk);
        check("R7 fallback quot", out_quot, 79);
        check("R7 fallback rem", out_rem, 99);
        in_pred = 17'd2000; in_div = 12'd3000; in_rem = 32'd48006000;
        @(negedge clk);
        check("R4 exact fit quot", out_quot, 16002);
        check("R6 exact fit rem", out_rem, 0);
        last_q = 16002;
        last_r = 0;

        // R9: idle cycles with changing inputs.
        in_valid = 1'b0; in_pred = 17'd77; in_div = 12'd3; in_rem = 32'd999;
        @(negedge clk);
        check("R2 drain", out_valid, 0);
        check("R9 hold quot", out_quot, last_q);
        check("R9 hold rem", out_rem, last_r);
        check("R9 hold err", out_err, 0);
        in_rem = 32'd5;
        @(negedge clk);
        check("R9 still held", out_quot, last_q);

        // R1: reset clears results.
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset quot", out_quot, 0);
        check("R1 reset valid", out_valid, 0);

        finished = 1'b1;
        finish_run();
    end
endmodule